// File: doc/BRIEF.md
# Reference-Tracking PLL Mode Controller

This block selects the operating mode of a digital phase-locked loop that follows an external timing reference. It watches a phase-error magnitude, a lock-detect flag and the health of the selected and standby references, and moves between six modes: free-run, pre-locked, locked, lost-phase, pre-locked(2) and holdover. The current mode is published as a 3-bit code that the loop filter and the reference selector decode.

When the phase error of a locked loop rises above a programmable limit, the controller enters lost-phase and gives the loop a bounded time to pull back onto the same reference. A slow timebase tick measures that time, and a parameter sets the count. If the time runs out, the controller emits a one-cycle disqualify pulse for the reference. It then moves to a second acquisition state if a good standby is present, and to holdover if none is. In holdover it strobes a frequency freeze once and keeps the proportional path of the loop disabled. A restored higher-priority reference in revertive operation also starts a new acquisition.

Top module: `pll_mode_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the mode at free-run (code 000) and clears the disqualify, freeze and proportional-disable outputs.
- R2: Mode codes are 000 free-run, 001 holdover, 010 pre-locked, 011 pre-locked(2), 100 locked and 101 lost-phase. Free-run moves to pre-locked once the selected reference is valid, and it stays in free-run while the reference is not valid. Pre-locked moves to locked when lock-detect is high.
- R3: The phase-error limit is (L+1)*LIMIT_STEP, where L is the 3-bit limit field. Locked moves to lost-phase only when the phase error is strictly greater than that limit.
- R4: In lost-phase the controller returns to locked, keeping the same reference, when lock-detect is high and the phase error is no more than the limit. Each new lost-phase episode starts its timeout count from zero.
- R5: The TIMEOUT_TICKS-th timebase tick inside one lost-phase episode, with no regain, ends the episode. The disqualify output goes high for exactly one cycle, on the same clock edge as the mode change.
- R6: On a timeout the next mode is pre-locked(2) when the standby-valid input is high, and holdover when it is low.
- R7: In locked, loss of the selected reference moves the mode to holdover. This takes priority over a phase-error excursion in the same cycle.
- R8: Holdover moves to pre-locked(2) when the reference-applied input is high.
- R9: When revertive operation is enabled, a higher-priority-restored indication moves locked or holdover to pre-locked(2). When revertive operation is disabled, the indication has no effect.
- R10: The freeze strobe is high for exactly the first cycle of each holdover stay. The proportional-disable output is high for every cycle in holdover and low in every other mode.
- R11: Pre-locked(2) moves to locked when lock-detect is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_err | input | ERR_W | Magnitude of the measured phase error |
| err_limit_sel | input | 3 | Phase-error limit field L |
| lock_ok | input | 1 | Lock-detect indication |
| sel_ref_ok | input | 1 | Selected reference is valid |
| standby_ok | input | 1 | A known-good standby reference exists |
| ref_applied | input | 1 | A reference has been selected and applied to the loop |
| revert_en | input | 1 | Revertive operation enable |
| hi_prio_back | input | 1 | A higher-priority reference has been restored |
| tb_tick | input | 1 | Slow timebase tick, one cycle wide |
| mode | output | 3 | Current mode code |
| disq_pulse | output | 1 | One-cycle disqualify of the current reference |
| freeze_stb | output | 1 | One-cycle freeze of the frequency offset on holdover entry |
| prop_off | output | 1 | Proportional path disabled |

## Verification
The limit comparison is swept over all eight values of the limit field. For each value the phase error is set exactly at the computed limit and then one above it, which tells a strict comparison from a non-strict one and a correct scale from a wrong one. Timeout runs give exactly TIMEOUT_TICKS-1 ticks and then one more, with and without a standby. These runs show whether the counter is off by one and whether it clears between episodes, and they tell the two exit branches apart. Further sequences drive reference loss together with a phase excursion, and revertive restore with the enable on and off. These show the priority order and confirm that an indication ignored in holdover leaves the mode and its outputs unchanged.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;
  typedef enum logic [2:0] {
    MODE_FREE  = 3'b000,
    MODE_HOLD  = 3'b001,
    MODE_PRE   = 3'b010,
    MODE_PRE2  = 3'b011,
    MODE_LOCK  = 3'b100,
    MODE_LOST  = 3'b101
  } mode_e;
endpackage

// File: rtl/pmc_err_limit.sv
module pmc_err_limit #(
  parameter int ERR_W      = 8,
  parameter int LIMIT_STEP = 16
) (
  input  logic [ERR_W-1:0] phase_err,
  input  logic [2:0]       limit_sel,
  output logic             over
);
  localparam int LW = ERR_W + 4;
  logic [LW-1:0] limit;

  always_comb begin
    limit = (LW'(limit_sel) + LW'(1)) * LW'(LIMIT_STEP);
    over  = LW'(phase_err) > limit;
  end

  always_comb begin
    assert_limit_range_R3: assert (limit >= LW'(LIMIT_STEP));
  end
endmodule

// File: rtl/pmc_regain_timer.sv
module pmc_regain_timer #(
  parameter int TIMEOUT_TICKS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int CW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);
  logic [CW-1:0] cnt;

  assign expire = run && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (expire)   cnt <= '0;
    else if (tick)     cnt <= cnt + CW'(1);
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  assert_clear_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> cnt == '0);
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pll_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       over,
  input  logic       expire,
  input  logic       lock_ok,
  input  logic       sel_ref_ok,
  input  logic       standby_ok,
  input  logic       ref_applied,
  input  logic       revert_en,
  input  logic       hi_prio_back,
  output logic [2:0] mode_o,
  output logic       lost_o,
  output logic       disq_o,
  output logic       freeze_o,
  output logic       prop_off_o
);
  mode_e cur, nxt;
  logic  disq_n;
  logic  revert;

  assign revert = revert_en && hi_prio_back;

  always_comb begin
    nxt    = cur;
    disq_n = 1'b0;
    unique case (cur)
      MODE_FREE: if (sel_ref_ok) nxt = MODE_PRE;
      MODE_PRE:  if (lock_ok) nxt = MODE_LOCK;
      MODE_PRE2: if (lock_ok) nxt = MODE_LOCK;
      MODE_LOCK: begin
        if (!sel_ref_ok)  nxt = MODE_HOLD;
        else if (revert)  nxt = MODE_PRE2;
        else if (over)    nxt = MODE_LOST;
      end
      MODE_LOST: begin
        if (lock_ok && !over) nxt = MODE_LOCK;
        else if (expire) begin
          disq_n = 1'b1;
          nxt    = standby_ok ? MODE_PRE2 : MODE_HOLD;
        end
      end
      MODE_HOLD: if (ref_applied || revert) nxt = MODE_PRE2;
      default:   nxt = MODE_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur        <= MODE_FREE;
      disq_o     <= 1'b0;
      freeze_o   <= 1'b0;
      prop_off_o <= 1'b0;
    end else begin
      cur        <= nxt;
      disq_o     <= disq_n;
      freeze_o   <= (nxt == MODE_HOLD) && (cur != MODE_HOLD);
      prop_off_o <= (nxt == MODE_HOLD);
    end
  end

  assign mode_o = cur;
  assign lost_o = (cur == MODE_LOST);

  assert_disq_single_R5: assert property (@(posedge clk) disable iff (rst)
    disq_o |=> !disq_o);
  assert_disq_from_lost_R5: assert property (@(posedge clk) disable iff (rst)
    disq_o |-> $past(cur) == MODE_LOST);
  assert_freeze_entry_R10: assert property (@(posedge clk) disable iff (rst)
    freeze_o |-> (cur == MODE_HOLD) && ($past(cur) != MODE_HOLD));
  assert_prop_hold_R10: assert property (@(posedge clk) disable iff (rst)
    prop_off_o == (cur == MODE_HOLD));
  assert_lost_cause_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(cur) == MODE_LOCK && cur == MODE_LOST) |-> $past(over));
  assert_timeout_exit_R6: assert property (@(posedge clk) disable iff (rst)
    disq_o |-> (cur == MODE_PRE2 || cur == MODE_HOLD));
endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl #(
  parameter int ERR_W         = 8,
  parameter int LIMIT_STEP    = 16,
  parameter int TIMEOUT_TICKS = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ERR_W-1:0] phase_err,
  input  logic [2:0]       err_limit_sel,
  input  logic             lock_ok,
  input  logic             sel_ref_ok,
  input  logic             standby_ok,
  input  logic             ref_applied,
  input  logic             revert_en,
  input  logic             hi_prio_back,
  input  logic             tb_tick,
  output logic [2:0]       mode,
  output logic             disq_pulse,
  output logic             freeze_stb,
  output logic             prop_off
);
  logic over, expire, lost;

  pmc_err_limit #(.ERR_W(ERR_W), .LIMIT_STEP(LIMIT_STEP)) u_limit (
    .phase_err (phase_err),
    .limit_sel (err_limit_sel),
    .over      (over)
  );

  pmc_regain_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (lost),
    .tick   (tb_tick),
    .expire (expire)
  );

  pmc_mode_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .over         (over),
    .expire       (expire),
    .lock_ok      (lock_ok),
    .sel_ref_ok   (sel_ref_ok),
    .standby_ok   (standby_ok),
    .ref_applied  (ref_applied),
    .revert_en    (revert_en),
    .hi_prio_back (hi_prio_back),
    .mode_o       (mode),
    .lost_o       (lost),
    .disq_o       (disq_pulse),
    .freeze_o     (freeze_stb),
    .prop_off_o   (prop_off)
  );
endmodule

// File: tb/pll_mode_ctrl_test.sv
module pll_mode_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int ERR_W = 8;
  localparam int STEP  = 16;
  localparam int TMO   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ERR_W-1:0] phase_err = '0;
  logic [2:0] err_limit_sel = '0;
  logic lock_ok = 0, sel_ref_ok = 0, standby_ok = 0, ref_applied = 0;
  logic revert_en = 0, hi_prio_back = 0, tb_tick = 0;
  logic [2:0] mode;
  logic disq_pulse, freeze_stb, prop_off;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_mode_ctrl #(.ERR_W(ERR_W), .LIMIT_STEP(STEP), .TIMEOUT_TICKS(TMO)) uut (
    .clk(clk), .rst(rst), .phase_err(phase_err), .err_limit_sel(err_limit_sel),
    .lock_ok(lock_ok), .sel_ref_ok(sel_ref_ok), .standby_ok(standby_ok),
    .ref_applied(ref_applied), .revert_en(revert_en), .hi_prio_back(hi_prio_back),
    .tb_tick(tb_tick), .mode(mode), .disq_pulse(disq_pulse),
    .freeze_stb(freeze_stb), .prop_off(prop_off)
  );

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick_pulse();
    tb_tick = 1; cyc(); tb_tick = 0; cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    chk("R1 mode", mode, 0);
    chk("R1 disq", disq_pulse, 0);
    chk("R1 freeze", freeze_stb, 0);
    chk("R1 prop", prop_off, 0);
    rst = 0;
    cyc();
    chk("R2 free-run holds", mode, 0);
    sel_ref_ok = 1; cyc();
    chk("R2 pre-locked", mode, 2);
    cyc();
    chk("R2 waits lock", mode, 2);
    lock_ok = 1; cyc();
    chk("R2 locked", mode, 4);

    for (int s = 0; s < 8; s++) begin
      int lim;
      lim = (s + 1) * STEP;
      err_limit_sel = 3'(s);
      phase_err = ERR_W'(lim); cyc();
      chk("R3 at limit stays locked", mode, 4);
      phase_err = ERR_W'(lim + 1); cyc();
      chk("R3 above limit lost", mode, 5);
      phase_err = '0; cyc();
      chk("R4 regain", mode, 4);
    end

    err_limit_sel = 0;
    standby_ok = 1;
    phase_err = 200; cyc();
    chk("R4 lost again", mode, 5);
    tick_pulse(); tick_pulse();
    phase_err = 0; cyc();
    chk("R4 regain mid-count", mode, 4);
    phase_err = 200; cyc();
    chk("R4 new episode", mode, 5);
    for (int k = 0; k < TMO - 1; k++) tick_pulse();
    chk("R4 counter restarted", mode, 5);
    chk("R5 no early disq", disq_pulse, 0);
    tb_tick = 1; cyc();
    chk("R6 standby to pre2", mode, 3);
    chk("R5 disq pulse", disq_pulse, 1);
    tb_tick = 0; phase_err = 0; cyc();
    chk("R5 disq one cycle", disq_pulse, 0);
    chk("R11 pre2 locks", mode, 4);

    standby_ok = 0;
    phase_err = 200; cyc();
    chk("R6 lost", mode, 5);
    for (int k = 0; k < TMO - 1; k++) tick_pulse();
    tb_tick = 1; cyc();
    chk("R6 no standby to holdover", mode, 1);
    chk("R5 disq pulse 2", disq_pulse, 1);
    chk("R10 freeze", freeze_stb, 1);
    chk("R10 prop", prop_off, 1);
    tb_tick = 0; cyc();
    chk("R10 freeze ends", freeze_stb, 0);
    chk("R10 prop held", prop_off, 1);
    chk("R5 disq clears", disq_pulse, 0);

    hi_prio_back = 1; cyc();
    chk("R9 ignored without revert", mode, 1);
    chk("R9 ignored prop", prop_off, 1);
    chk("R9 ignored freeze", freeze_stb, 0);
    hi_prio_back = 0;
    phase_err = 0; ref_applied = 1; cyc();
    chk("R8 applied to pre2", mode, 3);
    chk("R10 prop off after hold", prop_off, 0);
    ref_applied = 0; cyc();
    chk("R11 locked", mode, 4);

    sel_ref_ok = 0; phase_err = 200; cyc();
    chk("R7 ref loss priority", mode, 1);
    chk("R10 freeze again", freeze_stb, 1);
    revert_en = 1; hi_prio_back = 1; cyc();
    chk("R9 revert from holdover", mode, 3);
    hi_prio_back = 0; sel_ref_ok = 1; phase_err = 0; cyc();
    chk("R11 relock", mode, 4);
    hi_prio_back = 1; cyc();
    chk("R9 revert from locked", mode, 3);
    hi_prio_back = 0; cyc();
    chk("R11 relock 2", mode, 4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule